// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

An eight-bit storage register (width set by a parameter) whose contents can be held, moved one place toward the low end, moved one place toward the high end, or replaced from a parallel bus. The action is chosen by a two-bit mode input and happens on the rising clock edge. The parallel bus is bidirectional. For synthesis it is split into a data-in vector, a data-out vector and a drive-enable. The surrounding logic combines these into a tristate pin.

Both end stages of the register are also brought out as serial outputs, and each end has its own serial input. One device can therefore serve as a processor-visible byte register, a serial transmitter and a serial receiver at the same time. In a typical SPI-style use, the host loads a byte over the bus and then applies eight shift-toward-low clocks. Bit 0 leaves first while the returning bits enter at the top. After that, the host reads the byte that came back.

An active-low clear empties the register at once, without waiting for a clock.

Top module: `bidir_shift_reg`

## Requirements
- R1: With mode 2'b00 (hold), a rising clock edge leaves the stored value unchanged.
- R2: With mode 2'b01 (shift toward low), a rising edge stores {shl_in, q[W-1:1]}. Bit 0 is therefore presented first on first_out.
- R3: With mode 2'b10 (shift toward high), a rising edge stores {q[W-2:0], shr_in}. The top bit is presented on last_out.
- R4: With mode 2'b11 (load), a rising edge stores bus_in.
- R5: bus_drive is high exactly when oe_a_n and oe_b_n are both low and mode is not 2'b11. In load mode the bus is released whatever the enables are.
- R6: first_out always equals bit 0 of the stored value and last_out always equals bit W-1, whatever the enables and the mode. bus_out always shows the stored value.
- R7: A low level on clr_n forces the stored value to zero immediately, with no clock edge needed.
- R8: While clr_n is held low, clock edges in any mode leave the stored value at zero.
- R9: The stored value changes only on a rising clock edge. Between edges, changing the data inputs has no effect.
- R10: This register and a second one joined in a ring exchange their full contents after eight shift-toward-low clocks. The ring runs first_out to the partner's shift input, and the partner's low-end output back to shl_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; actions on rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift toward low, 10 shift toward high, 11 load |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | W | Parallel data from the bus |
| bus_out | output | W | Stored value toward the bus pins |
| bus_drive | output | 1 | High when the bus pins should be driven |
| shl_in | input | 1 | Serial input entering bit W-1 when shifting toward low |
| shr_in | input | 1 | Serial input entering bit 0 when shifting toward high |
| first_out | output | 1 | Bit 0 of the register, always driven |
| last_out | output | 1 | Bit W-1 of the register, always driven |

## Verification
Two pairs of functions can land in one cycle, and the bench sets up both on purpose.

The first pair is the clear and a clocked load. The bench holds clr_n low across an edge with load mode selected and a full-ones bus. It then judges the result by the stored value, which must read zero, and by a correct load once clr_n is released.

The second pair is load mode and enabled bus drive. The bench sweeps all sixteen mode and enable combinations and expects bus_drive low whenever load is selected, even with both enables low.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_SHR  = 2'b10,
    MODE_LOAD = 2'b11
  } bsr_mode_e;

endpackage

// File: rtl/bsr_stage_mux.sv
module bsr_stage_mux
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  bsr_mode_e      mode,
  input  logic [W-1:0]   q,
  input  logic [W-1:0]   bus_in,
  input  logic           shl_in,
  input  logic           shr_in,
  output logic [W-1:0]   d
);

  localparam int TOP = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic from_upper;
    logic from_lower;
    logic nxt;

    if (i == TOP) begin : g_top
      assign from_upper = shl_in;
    end else begin : g_mid_u
      assign from_upper = q[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_lower = shr_in;
    end else begin : g_mid_l
      assign from_lower = q[i-1];
    end

    always_comb begin
      case (mode)
        MODE_HOLD: nxt = q[i];
        MODE_SHL:  nxt = from_upper;
        MODE_SHR:  nxt = from_lower;
        MODE_LOAD: nxt = bus_in[i];
        default:   nxt = q[i];
      endcase
    end

    assign d[i] = nxt;
  end

endmodule

// File: rtl/bsr_state_reg.sv
module bsr_state_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/bsr_port_ctrl.sv
module bsr_port_ctrl
  import bsr_pkg::*;
(
  input  bsr_mode_e mode,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output logic      drive
);

  logic enables_on;
  logic loading;

  assign enables_on = ~oe_a_n & ~oe_b_n;
  assign loading    = (mode == MODE_LOAD);
  assign drive      = enables_on & ~loading;

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  input  logic         shl_in,
  input  logic         shr_in,
  output logic         first_out,
  output logic         last_out
);

  localparam int TOP = W - 1;

  bsr_mode_e    mode_e;
  logic [W-1:0] q;
  logic [W-1:0] d;

  assign mode_e = bsr_mode_e'(mode);

  bsr_stage_mux #(.W(W)) u_mux (
    .mode   (mode_e),
    .q      (q),
    .bus_in (bus_in),
    .shl_in (shl_in),
    .shr_in (shr_in),
    .d      (d)
  );

  bsr_state_reg #(.W(W)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (d),
    .q     (q)
  );

  bsr_port_ctrl u_port (
    .mode   (mode_e),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .drive  (bus_drive)
  );

  assign bus_out   = q;
  assign first_out = q[0];
  assign last_out  = q[TOP];

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_e == MODE_HOLD) |=> $stable(bus_out));

  // R2
  shift_low_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_e == MODE_SHL) |=> bus_out == {$past(shl_in), $past(bus_out[TOP:1])});

  // R3
  shift_high_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_e == MODE_SHR) |=> bus_out == {$past(bus_out[TOP-1:0]), $past(shr_in)});

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_e == MODE_LOAD) |=> bus_out == $past(bus_in));

  // R5
  load_release_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_e == MODE_LOAD) |-> !bus_drive);

  // R8
  clear_hold_chk: assert property (@(posedge clk)
    !clr_n |-> (bus_out == '0));

endmodule

// File: tb/test_bidir_shift_reg.sv
module test_bidir_shift_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_drive;
  logic         shl_in = 1'b0;
  logic         shr_in = 1'b0;
  logic         first_out;
  logic         last_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bidir_shift_reg #(.W(W)) i_bidir_shift_reg (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode      (mode),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_drive (bus_drive),
    .shl_in    (shl_in),
    .shr_in    (shr_in),
    .first_out (first_out),
    .last_out  (last_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp;
    logic [W-1:0] partner;
    logic         bit_out;

    clr_n = 1'b0;
    tick();
    tick();
    // R7: reset state
    check("R7 reset value", bus_out, 0);
    check("R6 reset first_out", first_out, 0);
    check("R6 reset last_out", last_out, 0);
    clr_n = 1'b1;

    // R4 load, R1 hold, R9 no change between edges, over all byte values
    for (int v = 0; v < 256; v++) begin
      mode = 2'b11;
      bus_in = v[W-1:0];
      tick();
      check("R4 load", bus_out, v);
      check("R5 released in load", bus_drive, 0);
      bus_in = ~v[W-1:0];
      mode = 2'b00;
      @(negedge clk);
      #1;
      check("R9 no change off edge", bus_out, v);
      tick();
      check("R1 hold", bus_out, v);
      check("R6 first_out", first_out, v & 1);
      check("R6 last_out", last_out, (v >> 7) & 1);
    end

    // R5 and R6: enable and mode sweep
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 4; e++) begin
        mode = 2'b11;
        bus_in = 8'h81;
        tick();
        mode = m[1:0];
        oe_a_n = e[0];
        oe_b_n = e[1];
        #1;
        check("R5 drive", bus_drive, (e == 0 && m != 3) ? 1 : 0);
        check("R6 first_out independent of enables", first_out, 1);
        check("R6 last_out independent of enables", last_out, 1);
        tick();
      end
    end
    oe_a_n = 1'b1;
    oe_b_n = 1'b1;

    // R2: shift toward low, several patterns
    for (int p = 0; p < 6; p++) begin
      exp = W'((p * 8'h47) ^ 8'h5A);
      mode = 2'b11;
      bus_in = exp;
      tick();
      for (int k = 0; k < W; k++) begin
        mode = 2'b01;
        shl_in = ((p + k) % 3) == 0;
        #1;
        check("R2 first_out order", first_out, exp[0]);
        exp = {shl_in, exp[W-1:1]};
        tick();
        check("R2 shift low", bus_out, exp);
      end
    end

    // R3: shift toward high, several patterns
    for (int p = 0; p < 6; p++) begin
      exp = W'((p * 8'h2D) ^ 8'hC3);
      mode = 2'b11;
      bus_in = exp;
      tick();
      for (int k = 0; k < W; k++) begin
        mode = 2'b10;
        shr_in = ((p + k) % 2) == 1;
        #1;
        check("R3 last_out order", last_out, exp[W-1]);
        exp = {exp[W-2:0], shr_in};
        tick();
        check("R3 shift high", bus_out, exp);
      end
    end

    // R10: ring exchange with a modelled partner
    mode = 2'b11;
    bus_in = 8'hA5;
    tick();
    partner = 8'h3C;
    mode = 2'b01;
    for (int k = 0; k < W; k++) begin
      shl_in = partner[0];
      #1;
      bit_out = first_out;
      tick();
      partner = {bit_out, partner[W-1:1]};
    end
    check("R10 ring local", bus_out, 8'h3C);
    check("R10 ring partner", partner, 8'hA5);

    // R7: asynchronous clear between edges
    mode = 2'b11;
    bus_in = 8'hFF;
    tick();
    mode = 2'b00;
    clr_n = 1'b0;
    #1;
    check("R7 async clear", bus_out, 0);

    // R8: clear dominates load
    mode = 2'b11;
    bus_in = 8'hFF;
    tick();
    check("R8 clear over load", bus_out, 0);
    mode = 2'b01;
    shl_in = 1'b1;
    tick();
    check("R8 clear over shift", bus_out, 0);
    clr_n = 1'b1;
    mode = 2'b11;
    bus_in = 8'h96;
    tick();
    check("R8 load after release", bus_out, 8'h96);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule